// File: doc/BRIEF.md
# Triplex LCD Multiplex Drive Sequencer

This block sequences the drive of a one-third-duty liquid crystal panel with three backplane pins (A, B, C) and twelve segment lines, 36 display bits in all. From a latched 36-bit picture it produces, for every pin and every scan instant, a 2-bit level code. An external resistor ladder or DAC turns each code into one of four one-third-bias voltages. Each frame has three backplane phases. Each phase has two halves of opposite polarity, so the panel sees no net DC.

The frame advances on rising edges of an oscillator waveform. This waveform is the on-chip oscillator level, or an external one taken on pin A. Both are resynchronised into the system clock. A two-bit role field sets which pins drive a backplane, which pin passes the internal oscillator out, and which pin takes a clock in, so several devices can share one oscillator. A stop flag holds the sequencer at the start of a frame, so cascaded devices start in step.

Top module: `lcd_triplex_seq`

## Requirements
- R1: While `rst` is high (synchronous, active high), every level code is forced to 2'b01, `pc_osc` is 0 and the frame position returns to phase 0, first half.
- R2: The frame position advances once per oscillator rising edge. A frame is 192 edges: phase 0 (edges 0..63), phase 1 (64..127), phase 2 (128..191). After that it wraps to phase 0.
- R3: Level codes are 2'b11 full supply, 2'b10 two thirds, 2'b01 one third, 2'b00 ground. In the first 32 edges of a phase, the backplane matching the phase (A=0, B=1, C=2) carries 2'b11 and the other enabled backplanes carry 2'b01. Codes are registered and follow the frame position one clock later.
- R4: In the last 32 edges of a phase, every backplane and segment code is the bitwise complement of its first-half value.
- R5: Segment s shows bit `seg_bits[phase*12 + s]` and its code sits at `seg_code[2s+1:2s]`. In the first half, a set bit gives 2'b00 and a clear bit gives 2'b10.
- R6: Role 2'b01 (stand-alone): pins A, B and C are all backplanes, the frame runs from `int_osc`, and `pc_osc` stays 0.
- R7: Role 2'b00 (master): pin C carries the synchronised `int_osc` on `pc_osc` and `pc_code` stays 2'b01. Pin A is a backplane, and the frame runs from `int_osc`.
- R8: Role 2'b11 (slave): pin A is a clock input. The frame runs from `pa_osc_in` only, edges on `int_osc` have no effect, `pa_code` stays 2'b01, pin C is a backplane and `pc_osc` stays 0.
- R9: Role 2'b10 (unused code): pin A is a clock input and pin C carries the internal oscillator. `pa_code` and `pc_code` both stay 2'b01, and the frame runs from `pa_osc_in`.
- R10: While `sync_stop` is high, the frame position is held at phase 0, first half, and oscillator edges are ignored. After it falls, counting restarts from that position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| int_osc | input | 1 | On-chip oscillator waveform (asynchronous) |
| pa_osc_in | input | 1 | External oscillator waveform arriving on pin A |
| mode | input | 2 | Cascade role: 01 stand-alone, 00 master, 11 slave, 10 unused |
| sync_stop | input | 1 | Hold the sequencer at frame start |
| seg_bits | input | 36 | Latched picture, bit phase*12+segment |
| pa_code | output | 2 | Level code for pin A |
| pb_code | output | 2 | Level code for pin B |
| pc_code | output | 2 | Level code for pin C |
| seg_code | output | 24 | Level codes for the twelve segment lines, two bits each |
| pc_osc | output | 1 | Internal oscillator passed out on pin C |

## Verification
The assertions assume that the oscillator waveforms are much slower than `clk`. Each level must last several clocks, so that every rising edge passes the synchroniser as one tick. They also assume that `mode` changes only while both oscillator inputs are low, so a role switch creates no spurious edge. The bench drives each oscillator pulse high for four clocks and low for four. It changes the role and the picture only under reset, with both waveforms at zero, so every check lands on a settled frame position.

// File: rtl/lcd_tri_pkg.sv
package lcd_tri_pkg;

  localparam int NUM_BP = 3;

  localparam logic [1:0] LVL_GND  = 2'b00;
  localparam logic [1:0] LVL_LOW  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;
  localparam logic [1:0] LVL_FULL = 2'b11;

  localparam logic [1:0] LVL_IDLE = LVL_LOW;

  localparam logic [1:0] ROLE_MASTER = 2'b00;
  localparam logic [1:0] ROLE_ALONE  = 2'b01;
  localparam logic [1:0] ROLE_UNUSED = 2'b10;
  localparam logic [1:0] ROLE_SLAVE  = 2'b11;

  // Second half of a phase mirrors every level around mid scale
  function automatic logic [1:0] polar(input logic [1:0] code, input logic neg);
    return neg ? ~code : code;
  endfunction

endpackage

// File: rtl/lcd_tri_tick.sv
module lcd_tri_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic int_osc,
  input  logic ext_osc,
  input  logic use_ext,
  output logic tick,
  output logic int_lvl
);

  localparam int NSRC = 2;

  logic [NSRC-1:0] raw;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] lvl;

  assign raw = {ext_osc, int_osc};

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      logic [SYNC_STAGES-1:0] sync_q;
      logic                   prev_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          sync_q <= '0;
          prev_q <= 1'b0;
        end else begin
          sync_q <= {sync_q[SYNC_STAGES-2:0], raw[g]};
          prev_q <= sync_q[SYNC_STAGES-1];
        end
      end

      assign lvl[g]  = sync_q[SYNC_STAGES-1];
      assign rise[g] = sync_q[SYNC_STAGES-1] & ~prev_q;
    end
  endgenerate

  assign tick    = use_ext ? rise[1] : rise[0];
  assign int_lvl = lvl[0];

endmodule

// File: rtl/lcd_tri_frame.sv
module lcd_tri_frame #(
  parameter int NUM_PHASE = 3,
  parameter int PHASE_LEN = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic                         hold,
  output logic [$clog2(PHASE_LEN)-1:0] sub,
  output logic [$clog2(NUM_PHASE)-1:0] phase,
  output logic                         half
);

  localparam int SW   = $clog2(PHASE_LEN);
  localparam int PHW  = $clog2(NUM_PHASE);
  localparam int HALF = PHASE_LEN / 2;

  localparam logic [SW-1:0]  SUB_LAST   = SW'(PHASE_LEN - 1);
  localparam logic [PHW-1:0] PHASE_LAST = PHW'(NUM_PHASE - 1);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      sub   <= '0;
      phase <= '0;
    end else if (tick) begin
      if (sub == SUB_LAST) begin
        sub   <= '0;
        phase <= (phase == PHASE_LAST) ? '0 : phase + PHW'(1);
      end else begin
        sub <= sub + SW'(1);
      end
    end
  end

  assign half = (sub >= SW'(HALF));

endmodule

// File: rtl/lcd_tri_encode.sv
module lcd_tri_encode
  import lcd_tri_pkg::*;
#(
  parameter int NUM_SEG = 12,
  parameter int PHW     = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [PHW-1:0]              phase,
  input  logic                        half,
  input  logic [NUM_BP*NUM_SEG-1:0]   seg_bits,
  input  logic [NUM_BP-1:0]           bp_en,
  output logic [NUM_BP-1:0][1:0]      bp_code,
  output logic [NUM_SEG-1:0][1:0]     seg_code
);

  genvar b, s;
  generate
    for (b = 0; b < NUM_BP; b++) begin : g_bp
      logic [1:0] nxt;
      always_comb begin
        if (!bp_en[b])
          nxt = LVL_IDLE;
        else
          nxt = polar((phase == PHW'(b)) ? LVL_FULL : LVL_LOW, half);
      end
      always_ff @(posedge clk) begin
        if (rst) bp_code[b] <= LVL_IDLE;
        else     bp_code[b] <= nxt;
      end
    end

    for (s = 0; s < NUM_SEG; s++) begin : g_seg
      logic       lit;
      logic [1:0] nxt;
      always_comb begin
        lit = 1'b0;
        for (int p = 0; p < NUM_BP; p++)
          if (phase == PHW'(p)) lit = seg_bits[p*NUM_SEG + s];
        nxt = polar(lit ? LVL_GND : LVL_HIGH, half);
      end
      always_ff @(posedge clk) begin
        if (rst) seg_code[s] <= LVL_IDLE;
        else     seg_code[s] <= nxt;
      end
    end
  endgenerate

endmodule

// File: rtl/lcd_triplex_seq.sv
module lcd_triplex_seq
  import lcd_tri_pkg::*;
#(
  parameter int NUM_SEG     = 12,
  parameter int PHASE_LEN   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       int_osc,
  input  logic                       pa_osc_in,
  input  logic [1:0]                 mode,
  input  logic                       sync_stop,
  input  logic [NUM_BP*NUM_SEG-1:0]  seg_bits,
  output logic [1:0]                 pa_code,
  output logic [1:0]                 pb_code,
  output logic [1:0]                 pc_code,
  output logic [2*NUM_SEG-1:0]       seg_code,
  output logic                       pc_osc
);

  localparam int SW  = $clog2(PHASE_LEN);
  localparam int PHW = $clog2(NUM_BP);

  // Role decode: bit 1 makes pin A a clock input, bit 0 keeps pin C a backplane
  logic pa_is_clk_in;
  logic pc_is_bp;
  assign pa_is_clk_in = mode[1];
  assign pc_is_bp     = mode[0];

  logic           tick;
  logic           int_lvl;
  logic [SW-1:0]  sub;
  logic [PHW-1:0] phase;
  logic           half;

  lcd_tri_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .int_osc (int_osc),
    .ext_osc (pa_osc_in),
    .use_ext (pa_is_clk_in),
    .tick    (tick),
    .int_lvl (int_lvl)
  );

  lcd_tri_frame #(.NUM_PHASE(NUM_BP), .PHASE_LEN(PHASE_LEN)) u_frame (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .hold  (sync_stop),
    .sub   (sub),
    .phase (phase),
    .half  (half)
  );

  logic [NUM_BP-1:0]       bp_en;
  logic [NUM_BP-1:0][1:0]  bp_code;
  logic [NUM_SEG-1:0][1:0] seg_arr;

  assign bp_en = {pc_is_bp, 1'b1, ~pa_is_clk_in};

  lcd_tri_encode #(.NUM_SEG(NUM_SEG), .PHW(PHW)) u_enc (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .half     (half),
    .seg_bits (seg_bits),
    .bp_en    (bp_en),
    .bp_code  (bp_code),
    .seg_code (seg_arr)
  );

  assign pa_code  = bp_code[0];
  assign pb_code  = bp_code[1];
  assign pc_code  = bp_code[2];
  assign seg_code = seg_arr;

  always_ff @(posedge clk) begin
    if (rst) pc_osc <= 1'b0;
    else     pc_osc <= ~pc_is_bp & int_lvl;
  end

endmodule

// File: rtl/lcd_triplex_seq_chk.sv
module lcd_triplex_seq_chk #(
  parameter int PHASE_LEN = 64,
  parameter int SW        = 6,
  parameter int PHW       = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     mode,
  input logic           sync_stop,
  input logic           tick,
  input logic [SW-1:0]  sub,
  input logic [PHW-1:0] phase,
  input logic [1:0]     pa_code,
  input logic [1:0]     pb_code,
  input logic [1:0]     pc_code,
  input logic           pc_osc
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (pa_code == 2'b01 && pb_code == 2'b01 && pc_code == 2'b01 && !pc_osc));

  a_r2_phase_range: assert property (@(posedge clk) disable iff (rst)
    phase <= PHW'(2));

  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (tick && !sync_stop) |=>
      (($past(sub) == SW'(PHASE_LEN - 1)) ? (sub == '0) : (sub == $past(sub) + SW'(1))));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !sync_stop) |=> $stable(sub) && $stable(phase));

  a_r3_single_full: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pa_code == 2'b11, pb_code == 2'b11, pc_code == 2'b11}));

  a_r4_single_gnd: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pa_code == 2'b00, pb_code == 2'b00, pc_code == 2'b00}));

  a_r7_pc_idle: assert property (@(posedge clk) disable iff (rst)
    !mode[0] |=> pc_code == 2'b01);

  a_r8_pa_idle: assert property (@(posedge clk) disable iff (rst)
    mode[1] |=> pa_code == 2'b01);

  a_r6_pc_quiet: assert property (@(posedge clk) disable iff (rst)
    mode[0] |=> !pc_osc);

  a_r10_stop_clears: assert property (@(posedge clk) disable iff (rst)
    sync_stop |=> (sub == '0 && phase == '0));

endmodule

bind lcd_triplex_seq lcd_triplex_seq_chk #(
  .PHASE_LEN (PHASE_LEN),
  .SW        (SW),
  .PHW       (PHW)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .mode      (mode),
  .sync_stop (sync_stop),
  .tick      (tick),
  .sub       (sub),
  .phase     (phase),
  .pa_code   (pa_code),
  .pb_code   (pb_code),
  .pc_code   (pc_code),
  .pc_osc    (pc_osc)
);

// File: tb/test_lcd_triplex_seq.sv
module test_lcd_triplex_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 12;
  localparam int FRAME = 192;
  localparam int PLEN = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        int_osc = 1'b0;
  logic        pa_osc_in = 1'b0;
  logic [1:0]  mode = 2'b01;
  logic        sync_stop = 1'b0;
  logic [35:0] seg_bits = '0;
  logic [1:0]  pa_code, pb_code, pc_code;
  logic [23:0] seg_code;
  logic        pc_osc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_triplex_seq i_lcd_triplex_seq (
    .clk(clk), .rst(rst), .int_osc(int_osc), .pa_osc_in(pa_osc_in),
    .mode(mode), .sync_stop(sync_stop), .seg_bits(seg_bits),
    .pa_code(pa_code), .pb_code(pb_code), .pc_code(pc_code),
    .seg_code(seg_code), .pc_osc(pc_osc)
  );

  function automatic logic [1:0] exp_bp(int n, int bp);
    int nn = n % FRAME;
    int ph = nn / PLEN;
    bit hf = (nn % PLEN) >= PLEN/2;
    bit en = (bp == 0) ? !mode[1] : (bp == 2) ? mode[0] : 1'b1;
    logic [1:0] c;
    if (!en) return 2'b01;
    c = (ph == bp) ? 2'b11 : 2'b01;
    return hf ? ~c : c;
  endfunction

  function automatic logic [23:0] exp_seg(int n);
    int nn = n % FRAME;
    int ph = nn / PLEN;
    bit hf = (nn % PLEN) >= PLEN/2;
    logic [23:0] v;
    for (int s = 0; s < NSEG; s++) begin
      logic [1:0] c;
      c = seg_bits[ph*NSEG + s] ? 2'b00 : 2'b10;
      v[2*s +: 2] = hf ? ~c : c;
    end
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic check_frame(string tag, int n);
    chk({tag, " pin A"}, 32'(pa_code), 32'(exp_bp(n, 0)));
    chk({tag, " pin B"}, 32'(pb_code), 32'(exp_bp(n, 1)));
    chk({tag, " pin C"}, 32'(pc_code), 32'(exp_bp(n, 2)));
    chk({tag, " segs"},  32'(seg_code), 32'(exp_seg(n)));
  endtask

  task automatic wait_neg(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic pulse(bit ext, int k);
    for (int i = 0; i < k; i++) begin
      if (ext) pa_osc_in = 1'b1; else int_osc = 1'b1;
      wait_neg(4);
      if (ext) pa_osc_in = 1'b0; else int_osc = 1'b0;
      wait_neg(4);
    end
  endtask

  task automatic start(logic [1:0] m, logic [35:0] pic);
    @(negedge clk);
    rst = 1'b1; int_osc = 1'b0; pa_osc_in = 1'b0; sync_stop = 1'b0;
    mode = m; seg_bits = pic;
    wait_neg(3);
    rst = 1'b0;
    wait_neg(2);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; mode = 2'b00; int_osc = 1'b1;
    wait_neg(4);
    chk("R1 pin A", 32'(pa_code), 32'h1);
    chk("R1 pin B", 32'(pb_code), 32'h1);
    chk("R1 pin C", 32'(pc_code), 32'h1);
    chk("R1 segs", 32'(seg_code), 32'h555555);
    chk("R1 osc out", 32'(pc_osc), 32'h0);
    int_osc = 1'b0;
    wait_neg(2);
  endtask

  task automatic t_alone();
    start(2'b01, 36'h5A3_C96_0F1);
    check_frame("R6 R3 R5 start", 0);
    pulse(0, 31);  check_frame("R3 end of first half", 31);
    pulse(0, 1);   check_frame("R4 second half", 32);
    pulse(0, 37);  check_frame("R2 phase B", 69);
    pulse(0, 71);  check_frame("R2 phase C", 140);
    pulse(0, 51);  check_frame("R4 last edge", 191);
    pulse(0, 1);   check_frame("R2 wrap", 192);
    chk("R6 osc out quiet", 32'(pc_osc), 32'h0);
  endtask

  task automatic t_pattern();
    start(2'b01, 36'hFFF_000_ABC);
    pulse(0, 10);  check_frame("R5 phase A bits", 10);
    pulse(0, 60);  check_frame("R5 phase B clear bits", 70);
    pulse(0, 90);  check_frame("R5 phase C lit bits", 160);
  endtask

  task automatic t_master();
    start(2'b00, 36'h123_456_789);
    pulse(0, 100); check_frame("R7 master frame", 100);
    int_osc = 1'b1; wait_neg(4);
    chk("R7 osc passed high", 32'(pc_osc), 32'h1);
    int_osc = 1'b0; wait_neg(4);
    chk("R7 osc passed low", 32'(pc_osc), 32'h0);
    check_frame("R7 after extra edge", 101);
  endtask

  task automatic t_slave();
    start(2'b11, 36'hF0F_0F0_A5A);
    pulse(0, 10);  check_frame("R8 internal edges ignored", 0);
    pulse(1, 70);  check_frame("R8 external edges", 70);
    int_osc = 1'b1; wait_neg(4);
    chk("R8 osc out quiet", 32'(pc_osc), 32'h0);
    int_osc = 1'b0; wait_neg(4);
  endtask

  task automatic t_unused();
    start(2'b10, 36'h00F_FF0_3C3);
    pulse(0, 5);   check_frame("R9 internal edges ignored", 0);
    pulse(1, 140); check_frame("R9 external edges", 140);
    int_osc = 1'b1; wait_neg(4);
    chk("R9 osc passed", 32'(pc_osc), 32'h1);
    int_osc = 1'b0; wait_neg(4);
  endtask

  task automatic t_stop();
    start(2'b01, 36'h9C6_3A5_E17);
    pulse(0, 100); check_frame("R10 running", 100);
    sync_stop = 1'b1; wait_neg(3);
    check_frame("R10 cleared", 0);
    pulse(0, 20);  check_frame("R10 held", 0);
    sync_stop = 1'b0; wait_neg(1);
    pulse(0, 33);  check_frame("R10 resumed", 33);
  endtask

  initial begin
    wait_neg(2);
    t_reset();
    t_alone();
    t_pattern();
    t_master();
    t_slave();
    t_unused();
    t_stop();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule